// File: doc/BRIEF.md
# Bidirectional Byte Port with Single-Bit Set and Clear

This block is a general-purpose I/O port of eight pins. Each pin has a direction bit in a control register and a level bit in a data latch. A small register bus writes and reads both registers. A pin whose direction bit is 1 drives its latch bit. A pin whose direction bit is 0 is an input and is sampled from the external pin bus. A read of the data register returns a mixed byte: the live pin level for each input and the latch bit for each output.

The port also takes a single-bit command that sets or clears one bit. The command runs as an internal read-modify-write of the whole data register. It reads the mixed byte, forces the selected bit, and writes back all eight bits. The write-back therefore overwrites the latches of input pins with whatever levels those pins had at the read. Software that wants to keep input-pin latches intact must keep its own copy of the byte. While a command runs, register-bus writes are held off so that the two never land on the same edge.

Top module: `gpio_bitop_port`

## Requirements
- R1: After reset the control register and the data latch are 0x00, all `pin_oe` bits are 0, and `bit_busy`, `bit_done` and `bus_stall` are 0.
- R2: For every pin k, `pin_oe[k]` equals control bit k, and `pin_out[k]` carries latch bit k.
- R3: A read with `bus_addr`=0 (data register) returns, for each bit, the `pin_in` level where control is 0 and the latch bit where control is 1.
- R4: A read with `bus_addr`=1 (control register) returns the control register.
- R5: A write to the data register updates the latch bit of an input pin too, and that value appears on `pin_out` and on a data read once the pin is switched to output.
- R6: A set command (`bit_start` with `bit_clear`=0) leaves the latch equal to the mixed read-back byte, sampled one edge after the start edge, with bit `bit_idx` forced to 1.
- R7: A clear command (`bit_start` with `bit_clear`=1) does the same with bit `bit_idx` forced to 0, and input-pin latches are overwritten in the same way.
- R8: After the start edge `bit_busy` is high for exactly three cycles. `bit_done` then goes high for exactly one cycle, with `bit_busy` low and the new latch already visible.
- R9: A register-bus write that is presented while `bit_busy` is high raises `bus_stall`, leaves the target register unchanged, and takes effect on the first edge after the command finishes.
- R10: `bit_start` is ignored while a command is in progress. Neither a different index nor the operation seen during busy affects the result.
- R11: With control 0x3F, latch 0x80, pin 7 low and pin 6 high, setting bit 0 reads 0x40 and leaves the latch at 0x41, so pin 0 drives high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data register, 1 = control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| bus_stall | output | 1 | Write is being held off; keep it presented |
| bit_start | input | 1 | Starts a single-bit command |
| bit_clear | input | 1 | 0 = set the bit, 1 = clear it |
| bit_idx | input | 3 | Bit to be forced |
| bit_busy | output | 1 | Command in progress |
| bit_done | output | 1 | One-cycle pulse when the write-back is complete |
| pin_in | input | 8 | Sampled external pin levels |
| pin_out | output | 8 | Level driven on each pin |
| pin_oe | output | 8 | Output enable per pin |

## Verification
A corrupt latch shows up at once on `pin_out`, and on a data read for output pins. A latch bit held for an input pin stays hidden until that pin is switched to output, so the bench flips directions after its writes. A sequencer that captures the byte on the wrong edge, or that drops the forced bit, shows at `bit_done`, three cycles after the start. The bench compares against a byte computed from the direction, latch and pin values it applied. A write that leaks through the stall changes the control read-back on the very next cycle, while `bit_busy` is still high.

// File: rtl/gpio_bitop_port.sv
module gpio_bitop_port #(
  parameter int WIDTH = 8,
  localparam int IDXW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  output logic             bus_stall,
  input  logic             bit_start,
  input  logic             bit_clear,
  input  logic [IDXW-1:0]  bit_idx,
  output logic             bit_busy,
  output logic             bit_done,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_MODIFY, S_WRITE} seq_t;

  seq_t            state;
  logic [WIDTH-1:0] ctrl_q, latch_q, work_q, mixed;
  logic [IDXW-1:0] idx_q;
  logic            clr_q;
  logic            wr_req, wr_ok;

  assign mixed     = (ctrl_q & latch_q) | (~ctrl_q & pin_in);
  assign bit_busy  = (state != S_IDLE);
  assign wr_req    = bus_sel & bus_wr;
  assign bus_stall = wr_req & bit_busy;
  assign wr_ok     = wr_req & ~bit_busy;
  assign bus_rdata = bus_addr ? ctrl_q : mixed;
  assign pin_out   = latch_q;
  assign pin_oe    = ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ok && bus_addr) begin
      ctrl_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      latch_q  <= '0;
      work_q   <= '0;
      idx_q    <= '0;
      clr_q    <= 1'b0;
      bit_done <= 1'b0;
    end else begin
      bit_done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (wr_ok && !bus_addr) latch_q <= bus_wdata;
          if (bit_start) begin
            idx_q <= bit_idx;
            clr_q <= bit_clear;
            state <= S_READ;
          end
        end
        S_READ: begin
          work_q <= mixed;
          state  <= S_MODIFY;
        end
        S_MODIFY: begin
          work_q[idx_q] <= ~clr_q;
          state         <= S_WRITE;
        end
        default: begin
          latch_q  <= work_q;
          bit_done <= 1'b1;
          state    <= S_IDLE;
        end
      endcase
    end
  end

endmodule

module gpio_bitop_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic             bus_addr,
  input logic             bus_stall,
  input logic             bit_busy,
  input logic             bit_done,
  input logic [WIDTH-1:0] pin_out
);

  logic data_wr_taken;
  assign data_wr_taken = bus_sel & bus_wr & ~bus_addr & ~bus_stall;

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> (!bit_busy && $past(bit_busy)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done);

  // R9
  stall_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stall |-> bit_busy);

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_wr_taken && !bit_done) |=> ($stable(pin_out) || bit_done));

endmodule

bind gpio_bitop_port gpio_bitop_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_stall(bus_stall), .bit_busy(bit_busy),
  .bit_done(bit_done), .pin_out(pin_out)
);

// File: tb/gpio_bitop_port_tb.sv
module gpio_bitop_port_tb_top;
  logic       clk = 0, rst_n = 0;
  logic       bus_sel = 0, bus_wr = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       bus_stall;
  logic       bit_start = 0, bit_clear = 0;
  logic [2:0] bit_idx = 0;
  logic       bit_busy, bit_done;
  logic [7:0] pin_in = 0, pin_out, pin_oe;

  int tests = 0, fails = 0;
  logic [7:0] m_ctrl = 0, m_latch = 0;

  always #4 clk = ~clk;

  gpio_bitop_port dut_i (.*);

  function automatic logic [7:0] mix(input logic [7:0] c, l, p);
    return (c & l) | (~c & p);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    while (bus_stall) @(negedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (a) m_ctrl = d; else m_latch = d;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic bit_op(input logic clr, input logic [2:0] idx, input string tag);
    logic [7:0] exp;
    int bcnt;
    exp = mix(m_ctrl, m_latch, pin_in);
    if (clr) exp[idx] = 1'b0; else exp[idx] = 1'b1;
    @(negedge clk);
    bit_start = 1; bit_clear = clr; bit_idx = idx;
    @(negedge clk);
    bit_start = 0;
    bcnt = 0;
    while (bit_busy && bcnt < 10) begin bcnt++; @(negedge clk); end
    chk(bcnt == 3, "R8 busy cycles", 8'(bcnt), 8'd3);
    chk(bit_done == 1, "R8 done pulse", {7'd0, bit_done}, 8'd1);
    chk(pin_out == exp, tag, pin_out, exp);
    @(negedge clk);
    chk(bit_done == 0, "R8 done one cycle", {7'd0, bit_done}, 8'd0);
    m_latch = exp;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=00 expected=01");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(pin_oe == 0 && pin_out == 0, "R1 pins", pin_oe | pin_out, 8'h00);
    chk(!bit_busy && !bit_done && !bus_stall, "R1 flags",
        {5'd0, bit_busy, bit_done, bus_stall}, 8'h00);
    bus_read(1, rd); chk(rd == 8'h00, "R1 ctrl", rd, 8'h00);

    // R11 directed example
    bus_write(1, 8'h3F); bus_write(0, 8'h80);
    pin_in = 8'h40;
    bus_read(0, rd); chk(rd == 8'h40, "R11 read", rd, 8'h40);
    bit_op(0, 3'd0, "R11 latch");
    chk(pin_out == 8'h41 && pin_oe[0], "R11 pin0 high", pin_out, 8'h41);

    // R5 input latch takes effect on switch to output
    bus_write(1, 8'h00); bus_write(0, 8'hA5);
    pin_in = 8'h3C;
    bus_read(0, rd); chk(rd == 8'h3C, "R3 all inputs", rd, 8'h3C);
    bus_write(1, 8'hFF);
    chk(pin_out == 8'hA5, "R5 pin_out", pin_out, 8'hA5);
    bus_read(0, rd); chk(rd == 8'hA5, "R5 read", rd, 8'hA5);

    // R7 clear overwrites input latches
    bus_write(1, 8'h0F); bus_write(0, 8'hFF); pin_in = 8'h50;
    bit_op(1, 3'd2, "R7 clear");
    chk(pin_out[7:4] == 4'h5, "R7 input latch overwritten", pin_out, 8'h5B);

    // R9 stall
    bit_start = 1; bit_clear = 0; bit_idx = 3'd7;
    @(negedge clk);
    bit_start = 0;
    bus_sel = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 8'hC3;
    #1 chk(bus_stall == 1, "R9 stall high", {7'd0, bus_stall}, 8'd1);
    @(negedge clk);
    chk(bus_rdata == m_ctrl, "R9 ctrl unchanged", bus_rdata, m_ctrl);
    while (bus_stall) @(negedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    m_latch = mix(m_ctrl, m_latch, pin_in) | 8'h80;
    m_ctrl = 8'hC3;
    chk(pin_oe == 8'hC3, "R9 write landed", pin_oe, 8'hC3);
    chk(pin_out == m_latch, "R9 bit op intact", pin_out, m_latch);

    // R10 start while busy ignored
    bus_write(1, 8'hFF); bus_write(0, 8'h00);
    @(negedge clk);
    bit_start = 1; bit_clear = 0; bit_idx = 3'd1;
    @(negedge clk); bit_idx = 3'd6; bit_clear = 1;
    @(negedge clk);
    @(negedge clk); bit_start = 0;
    @(negedge clk);
    chk(pin_out == 8'h02, "R10 second start ignored", pin_out, 8'h02);
    m_latch = 8'h02;
    repeat (2) @(negedge clk);
    chk(!bit_busy, "R10 no restart", {7'd0, bit_busy}, 8'd0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [7:0] c, d;
      c = 8'($urandom); d = 8'($urandom);
      bus_write(1, c); bus_write(0, d);
      pin_in = 8'($urandom);
      chk(pin_oe == c, "R2 oe", pin_oe, c);
      chk(pin_out == d, "R2 out", pin_out, d);
      bus_read(0, rd); chk(rd == mix(c, d, pin_in), "R3 mix", rd, mix(c, d, pin_in));
      bus_read(1, rd); chk(rd == c, "R4 ctrl read", rd, c);
      if (i % 2) bit_op(1, 3'($urandom), "R7 random clear");
      else       bit_op(0, 3'($urandom), "R6 random set");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule